// File: doc/BRIEF.md
# Dual Event Counter Monitor

This block watches a bundle of event lanes and keeps two 40-bit counters of the events that software chooses. Each lane carries eight sub-event flags per cycle. Each counter has a selection register that names the lane and masks its sub-events. The selection register can also turn the per-cycle count into a single condition, compared against a threshold, inverted, or reduced to its rising edge.

Counting is gated twice. The counter must be enabled in its own selection register and also in a shared gate register. When a counter wraps past its maximum, a sticky status flag is set and the counter keeps running. Status flags are cleared by writing ones to a separate clear register. An interrupt line stays high while a flagged counter has its interrupt-enable set. Counters can be preloaded through the same write port, so software can arm a sampling period that ends in an overflow.

Top module: `two_ctr_pmu`

## Requirements
- R1: After reset every readable register reads zero and `irq` is low.
- R2: Counter i advances only while bit i of the gate register (address 4) and bit 22 (local enable) of its selection register are both set. Otherwise it holds its value.
- R3: Register addresses are: selection 0 at 0, selection 1 at 1, counter 0 at 2, counter 1 at 3, gate at 4, status at 5 (read only), clear at 6 (reads zero). A selection register stores code in bits 7:0, mask in bits 15:8, edge in bit 18, interrupt-enable in bit 20, local enable in bit 22, invert in bit 23 and threshold in bits 31:24. All other bits read zero. Clearing bit 22 leaves the other fields unchanged.
- R4: The code picks lane `code` of `events` (lane k in bits 8k+7:8k). The per-cycle count is the number of ones in lane AND mask. A code of 8 or more counts nothing. With threshold zero and edge clear, the counter adds that count each cycle, and invert has no effect.
- R5: With a non-zero threshold, the counter adds one in each cycle whose count is at least the threshold.
- R6: With invert set and a non-zero threshold, the counter adds one in each cycle whose count is below the threshold.
- R7: With edge set, the counter adds one only when the condition rises from 0 to 1. The condition is the thresholded test, or "count non-zero" when the threshold is zero, XOR invert. The previous condition is sampled every cycle and resets to 0.
- R8: A counter that wraps past 2^40-1 keeps the wrapped sum, and its status bit (bit i of address 5) is set on the same clock.
- R9: Writing the clear register clears the status bits written as one. Status bits written as zero are left unchanged.
- R10: `irq` is high while some status bit i is set and counter i has its interrupt-enable (bit 20) set. A flagged counter without that bit does not raise `irq`.
- R11: Writing a counter address loads the written value. The load takes priority over counting in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 40 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 40 | Read data, combinational from rd_addr |
| events | input | 64 | Eight event lanes of eight sub-event flags |
| irq | output | 1 | Overflow interrupt |

## Verification
Every register changes at the first rising edge after its write or event stimulus. The read port is combinational, so each result can be read one edge after the stimulus. Overflow status and `irq` also follow one edge after the wrapping cycle, because `irq` is decoded straight from the status flags. The bench applies inputs one time unit after an edge. It lines up the last event cycle with the write that closes the gate, so no stray counting edge gets into a result. It reads values back one time unit after the edge that produced them, before the next edge.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    localparam int NUM_CTR    = 2;
    localparam int CNT_W      = 40;
    localparam int DATA_W     = 40;
    localparam int ADDR_W     = 3;
    localparam int NUM_EVENTS = 8;
    localparam int LANE_W     = 8;
    localparam int SEL_W      = 32;
    localparam int THR_W      = 8;
    localparam int INC_W      = $clog2(LANE_W + 1);
    localparam int EV_BUS_W   = NUM_EVENTS * LANE_W;

    localparam int A_SEL_BASE = 0;
    localparam int A_CNT_BASE = A_SEL_BASE + NUM_CTR;
    localparam int A_GATE     = A_CNT_BASE + NUM_CTR;
    localparam int A_STAT     = A_GATE + 1;
    localparam int A_CLR      = A_STAT + 1;

    typedef struct packed {
        logic [THR_W-1:0] thresh;
        logic             inv;
        logic             local_en;
        logic             irq_en;
        logic             edge_det;
        logic [7:0]       mask;
        logic [7:0]       code;
    } evsel_t;

    function automatic evsel_t unpack_sel(input logic [SEL_W-1:0] w);
        evsel_t s;
        s.code     = w[7:0];
        s.mask     = w[15:8];
        s.edge_det = w[18];
        s.irq_en   = w[20];
        s.local_en = w[22];
        s.inv      = w[23];
        s.thresh   = w[31:24];
        return s;
    endfunction

    function automatic logic [SEL_W-1:0] pack_sel(input evsel_t s);
        logic [SEL_W-1:0] w;
        w        = '0;
        w[7:0]   = s.code;
        w[15:8]  = s.mask;
        w[18]    = s.edge_det;
        w[20]    = s.irq_en;
        w[22]    = s.local_en;
        w[23]    = s.inv;
        w[31:24] = s.thresh;
        return w;
    endfunction

endpackage

// File: rtl/pmu_event_filter.sv
module pmu_event_filter
    import pmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [EV_BUS_W-1:0] events,
    input  evsel_t              cfg,
    output logic [INC_W-1:0]    inc
);

    logic [LANE_W-1:0] lane;
    logic [INC_W-1:0]  count;
    logic              cond;
    logic              prev_q;
    logic              rise;

    always_comb begin
        lane = '0;
        for (int k = 0; k < NUM_EVENTS; k++) begin
            if (int'(cfg.code) == k) lane = events[k*LANE_W +: LANE_W];
        end
    end

    always_comb begin
        count = '0;
        for (int b = 0; b < LANE_W; b++) begin
            count = count + INC_W'(lane[b] & cfg.mask[b]);
        end
    end

    always_comb begin
        if (cfg.thresh == '0) cond = (count != '0) ^ cfg.inv;
        else                  cond = (THR_W'(count) >= cfg.thresh) ^ cfg.inv;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= cond;
    end

    assign rise = cond & ~prev_q;

    always_comb begin
        if (cfg.edge_det)              inc = INC_W'(rise);
        else if (cfg.thresh != '0)     inc = INC_W'(cond);
        else                           inc = count;
    end

    p_edge_gap_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg.edge_det && inc != '0) |=> (!$stable(cfg) || inc == '0))
        else $error("edge mode counted two cycles in a row");

    p_inc_bound_r4: assert property (@(posedge clk) disable iff (rst)
        inc <= INC_W'(LANE_W))
        else $error("increment above lane width");

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [INC_W-1:0] inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             ovf
);

    logic [CNT_W:0] sum;

    assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    assign ovf = en & ~load & sum[CNT_W];

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (en)   cnt_q <= sum[CNT_W-1:0];
    end

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!en && !load) |=> $stable(cnt_q))
        else $error("counter moved while disabled");

    p_load_r11: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(load_val)))
        else $error("preload not taken");

    p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (cnt_q <= CNT_W'(LANE_W)))
        else $error("wrapped value too large");

endmodule

// File: rtl/two_ctr_pmu.sv
module two_ctr_pmu
    import pmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    input  logic [EV_BUS_W-1:0] events,
    output logic                irq
);

    localparam logic [ADDR_W-1:0] AD_GATE = ADDR_W'(A_GATE);
    localparam logic [ADDR_W-1:0] AD_STAT = ADDR_W'(A_STAT);
    localparam logic [ADDR_W-1:0] AD_CLR  = ADDR_W'(A_CLR);

    logic [NUM_CTR-1:0]             gate_q;
    logic [NUM_CTR-1:0]             stat_q;
    logic [NUM_CTR-1:0]             ovf;
    logic [NUM_CTR-1:0]             ie_vec;
    logic [NUM_CTR-1:0][CNT_W-1:0]  cnt_all;
    logic [NUM_CTR-1:0][SEL_W-1:0]  sel_rd;
    logic                           clr_wr;
    logic [NUM_CTR-1:0]             clr_bits;

    assign clr_wr   = wr_en && (wr_addr == AD_CLR);
    assign clr_bits = clr_wr ? wr_data[NUM_CTR-1:0] : '0;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        localparam logic [ADDR_W-1:0] AD_SEL = ADDR_W'(A_SEL_BASE + i);
        localparam logic [ADDR_W-1:0] AD_CNT = ADDR_W'(A_CNT_BASE + i);

        evsel_t           sel_q;
        logic [INC_W-1:0] inc;
        logic             run;
        logic             load;
        logic [CNT_W-1:0] cnt_q;

        always_ff @(posedge clk) begin
            if (rst)                               sel_q <= '0;
            else if (wr_en && wr_addr == AD_SEL)   sel_q <= unpack_sel(wr_data[SEL_W-1:0]);
        end

        assign run  = gate_q[i] & sel_q.local_en;
        assign load = wr_en && (wr_addr == AD_CNT);

        pmu_event_filter u_filt (
            .clk    (clk),
            .rst    (rst),
            .events (events),
            .cfg    (sel_q),
            .inc    (inc)
        );

        pmu_counter u_cnt (
            .clk      (clk),
            .rst      (rst),
            .en       (run),
            .inc      (inc),
            .load     (load),
            .load_val (wr_data[CNT_W-1:0]),
            .cnt_q    (cnt_q),
            .ovf      (ovf[i])
        );

        assign cnt_all[i] = cnt_q;
        assign sel_rd[i]  = pack_sel(sel_q);
        assign ie_vec[i]  = sel_q.irq_en;

        p_set_r8: assert property (@(posedge clk) disable iff (rst)
            ovf[i] |=> stat_q[i])
            else $error("overflow flag not latched");

        p_clear_r9: assert property (@(posedge clk) disable iff (rst)
            (clr_bits[i] && !ovf[i]) |=> !stat_q[i])
            else $error("flag not cleared");

        p_keep_r9: assert property (@(posedge clk) disable iff (rst)
            (stat_q[i] && !clr_bits[i]) |=> stat_q[i])
            else $error("flag lost without clear");
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= '0;
            stat_q <= '0;
        end else begin
            if (wr_en && wr_addr == AD_GATE) gate_q <= wr_data[NUM_CTR-1:0];
            stat_q <= (stat_q & ~clr_bits) | ovf;
        end
    end

    assign irq = |(stat_q & ie_vec);

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_addr == ADDR_W'(A_SEL_BASE + i)) rd_data = DATA_W'(sel_rd[i]);
            if (rd_addr == ADDR_W'(A_CNT_BASE + i)) rd_data = DATA_W'(cnt_all[i]);
        end
        if (rd_addr == AD_GATE) rd_data = DATA_W'(gate_q);
        if (rd_addr == AD_STAT) rd_data = DATA_W'(stat_q);
    end

    p_irq_src_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> (stat_q != '0))
        else $error("irq without any flag");

    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (stat_q == '0 && gate_q == '0))
        else $error("state not cleared by reset");

endmodule

// File: tb/tb_two_ctr_pmu.sv
`timescale 1ns/1ps
module tb_two_ctr_pmu;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [39:0] wr_data;
    logic [2:0]  rd_addr;
    logic [39:0] rd_data;
    logic [63:0] events;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    two_ctr_pmu dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .events(events), .irq(irq)
    );

    localparam int NV = 8;
    // selection word, expected count of counter 0 after the lane-2 pattern 03,FF,00,01
    localparam logic [31:0] VSEL [NV] = '{
        32'h0040FF02,  // R4 full mask: 2+8+0+1
        32'h00400F02,  // R4 low-nibble mask: 2+4+0+1
        32'h0240FF02,  // R5 threshold 2
        32'h03C0FF02,  // R6 invert, threshold 3
        32'h0144FF02,  // R7 edge, threshold 1
        32'h0244FF02,  // R7 edge, threshold 2
        32'h0040FF09,  // R4 code out of range
        32'h0000FF02   // R2 local enable clear
    };
    localparam logic [39:0] VEXP [NV] = '{40'd11, 40'd7, 40'd2, 40'd3, 40'd2, 40'd1, 40'd0, 40'd0};
    localparam string VREQ [NV] = '{"R4", "R4", "R5", "R6", "R7", "R7", "R4", "R2"};
    localparam logic [7:0] PAT [4] = '{8'h03, 8'hFF, 8'h00, 8'h01};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [39:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk(input string req, input logic [39:0] got, input logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [39:0] exp);
        rd_addr = a;
        #0.5;
        chk(req, rd_data, exp);
    endtask

    task automatic lane2(input logic [7:0] v);
        events = 64'(v) << 16;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0; events = '0;
        repeat (3) tick();
        rst = 1'b0;

        // R1 reset state
        for (int a = 0; a < 6; a++) rd_chk("R1", 3'(a), 40'd0);
        chk("R1 irq", 40'(irq), 40'd0);

        // vector table, counter 0 on lane 2
        for (int v = 0; v < NV; v++) begin
            events = '0;
            wr(3'd4, 40'd0);
            wr(3'd2, 40'd0);
            wr(3'd0, 40'(VSEL[v]));
            tick();
            wr(3'd4, 40'd3);
            for (int k = 0; k < 3; k++) begin
                lane2(PAT[k]);
                tick();
            end
            lane2(PAT[3]);
            wr(3'd4, 40'd0);
            events = '0;
            rd_chk(VREQ[v], 3'd2, VEXP[v]);
        end

        // R3 field storage and readback
        wr(3'd1, 40'hFF_FFFF_FFFF);
        rd_chk("R3", 3'd1, 40'h00FFD4FFFF);
        wr(3'd1, 40'h00FF94FFFF);
        rd_chk("R3 enable clear keeps fields", 3'd1, 40'h00FF94FFFF);
        wr(3'd1, 40'd0);
        rd_chk("R3 clear register reads zero", 3'd6, 40'd0);

        // R2 gate bit for the other counter only
        wr(3'd2, 40'd5);
        wr(3'd0, 40'h0040FF02);
        wr(3'd4, 40'd2);
        lane2(8'hFF);
        tick();
        wr(3'd4, 40'd0);
        events = '0;
        rd_chk("R2 gate", 3'd2, 40'd5);
        rd_chk("R3 gate readback", 3'd4, 40'd0);

        // R11 preload wins over counting, then counting resumes
        wr(3'd4, 40'd1);
        lane2(8'h07);
        wr(3'd2, 40'd100);
        rd_chk("R11 load priority", 3'd2, 40'd100);
        wr(3'd4, 40'd0);
        events = '0;
        rd_chk("R11 count after load", 3'd2, 40'd103);

        // R8 / R10 wrap on counter 1 with interrupt enable
        wr(3'd1, 40'h0050FF02);
        wr(3'd3, 40'hFF_FFFF_FFFE);
        wr(3'd4, 40'd2);
        lane2(8'h07);
        wr(3'd4, 40'd0);
        events = '0;
        rd_chk("R8 wrapped value", 3'd3, 40'd1);
        rd_chk("R8 status", 3'd5, 40'd2);
        chk("R10 irq set", 40'(irq), 40'd1);

        // R9 zero bits leave flags, one bits clear
        wr(3'd6, 40'd1);
        rd_chk("R9 unrelated clear", 3'd5, 40'd2);
        chk("R10 irq held", 40'(irq), 40'd1);
        wr(3'd6, 40'd2);
        rd_chk("R9 cleared", 3'd5, 40'd0);
        chk("R10 irq drops", 40'(irq), 40'd0);

        // R10 flag without interrupt enable on counter 0
        wr(3'd0, 40'h0040FF02);
        wr(3'd2, 40'hFF_FFFF_FFFF);
        wr(3'd4, 40'd1);
        lane2(8'h01);
        wr(3'd4, 40'd0);
        events = '0;
        rd_chk("R8 wrap to zero", 3'd2, 40'd0);
        rd_chk("R8 status bit0", 3'd5, 40'd1);
        chk("R10 no irq without enable", 40'(irq), 40'd0);
        wr(3'd6, 40'd3);
        rd_chk("R9 clear both", 3'd5, 40'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule